// File: doc/BRIEF.md
# Four-channel DMA transfer sequencer

This block runs the per-step service loop of a small four-channel DMA engine. Software loads each channel with a transfer kind, an address direction, a 24-bit start address and a 16-bit length, and the load arms the channel. Each pulse on `step` starts one service pass. The pass visits the armed channels in ascending index order and moves exactly one byte for each of them. The byte goes between the device attached to that channel and a single shared synchronous memory port, in the direction that the channel's kind selects.

A channel's length is tested before it is decremented. When the length is already zero at the moment the channel is visited, the channel is disarmed, its sticky status bit is raised and its end-of-transfer line pulses. The transfer for that visit still takes place. A programmed length N therefore moves N+1 bytes. A global address-mode input picks one of two stepping modes. In one, the whole 24-bit address steps. In the other, only the low 16 bits step and wrap inside a 64 KiB page.

Each device handshake is a plain valid/ready pair for each channel. The sequencer waits on a channel for as long as its device holds off, so slow devices simply stretch the pass.

Top module: `dma4_seq`

## Requirements
- R1: After reset no channel is armed, `status` is zero and `busy` is low. A `cfg_we` pulse aimed at an unarmed channel loads its kind, direction, address and length, and it shows that channel's `working` bit from the next cycle. A `cfg_we` aimed at an armed channel is ignored.
- R2: One step services every armed channel exactly once, in the order 0, 1, 2, 3. A channel's transfer completes before the next channel is touched.
- R3: If an armed channel's length is zero when it is visited, its `working` bit clears, its `status` bit sets and its `eot` bit is high for that one cycle. The transfer is still performed. The length drops by one on every visit, so a length of N yields N+1 transfers.
- R4: Kind code 00 (verify) takes one byte from the device and makes no memory access. Code 01 takes one byte from the device and writes it to memory at the channel's current address. Codes 10 and 11 read memory at the current address and hand the byte to the device.
- R5: With the direction bit at 1 the address decreases by one after every transfer. With it at 0 the address increases by one.
- R6: With `addr_wrap16` high only the low 16 address bits step, wrapping modulo 65536, and bits 23:16 stay fixed. With it low, all 24 bits step modulo 2^24.
- R7: A step while no channel is armed makes no memory access and no device handshake.
- R8: While the device has not completed the handshake, the sequencer holds its request on the same channel, with `dev_in_ready` one-hot. A memory write happens only in the cycle in which the device-input handshake completes.
- R9: `status` bits are sticky until a `status_clr` pulse clears them.
- R10: A memory read raises `mem_re` for one cycle. `mem_rdata` is taken one cycle later, and the byte then appears on `dev_out_data` with `dev_out_valid`.
- R11: `busy` is high from the cycle after a step is accepted until the pass ends. A `step` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for one channel |
| cfg_ch | input | 2 | Channel selected by the load |
| cfg_kind | input | 2 | Transfer kind: 00 verify, 01 device to memory, 1x memory to device |
| cfg_dec | input | 1 | Address direction: 1 down, 0 up |
| cfg_addr | input | 24 | Start address |
| cfg_len | input | 16 | Length (transfers minus one) |
| addr_wrap16 | input | 1 | 1 steps only the low 16 address bits |
| step | input | 1 | Start one service pass |
| busy | output | 1 | Pass in progress |
| working | output | 4 | Armed channel mask |
| status | output | 4 | Sticky terminal-count bits |
| status_clr | input | 1 | Clears all status bits |
| eot | output | 4 | One-cycle end-of-transfer pulse per channel |
| mem_addr | output | 24 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| dev_in_valid | input | 4 | Device has a byte, per channel |
| dev_in_ready | output | 4 | Sequencer takes the byte, per channel |
| dev_in_data | input | 32 | Device bytes, channel i in bits 8i+7:8i |
| dev_out_valid | output | 4 | Sequencer offers a byte, per channel |
| dev_out_ready | input | 4 | Device accepts the byte, per channel |
| dev_out_data | output | 8 | Byte offered to the device |

## Verification
A wrong length or terminal test shows up first as an `eot` pulse on the wrong visit, and the following step then shows an armed mask or status bit that differs from the reference. A corrupted address or direction bit is visible on `mem_addr` at the very next memory transfer of that channel. A verify channel only reveals it once it is reloaded with a memory kind. Order or skipping faults appear on the handshake that completes in the same pass, as a channel index that does not match the head of the expected queue.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  typedef enum logic [1:0] {
    XK_VERIFY  = 2'd0,
    XK_DEV2MEM = 2'd1,
    XK_MEM2DEV = 2'd2
  } xfer_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SCAN,
    S_DIN,
    S_MRD,
    S_MCAP,
    S_DOUT
  } seq_state_e;

  // Map a programmed kind code to the transfer performed
  function automatic xfer_kind_e kind_of(input logic [1:0] code);
    case (code)
      2'b00:   return XK_VERIFY;
      2'b01:   return XK_DEV2MEM;
      default: return XK_MEM2DEV;
    endcase
  endfunction

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan #(
  parameter int A_W  = 24,
  parameter int L_W  = 16,
  parameter int PG_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [1:0]     ld_kind,
  input  logic           ld_dec,
  input  logic [A_W-1:0] ld_addr,
  input  logic [L_W-1:0] ld_len,
  input  logic           svc_begin,
  input  logic           adv,
  input  logic           wrap16,
  output logic [1:0]     kind_code,
  output logic           dec,
  output logic [A_W-1:0] addr,
  output logic [L_W-1:0] len,
  output logic           working,
  output logic           tc
);

  // Address after one transfer: whole register or low page only
  function automatic logic [A_W-1:0] step_addr(input logic [A_W-1:0] a,
                                               input logic down,
                                               input logic pg);
    logic [A_W-1:0]  full;
    logic [PG_W-1:0] low;
    full = down ? a - A_W'(1) : a + A_W'(1);
    low  = down ? a[PG_W-1:0] - PG_W'(1) : a[PG_W-1:0] + PG_W'(1);
    return pg ? {a[A_W-1:PG_W], low} : full;
  endfunction

  function automatic logic [L_W-1:0] dec_len(input logic [L_W-1:0] l);
    return l - L_W'(1);
  endfunction

  assign tc = svc_begin && (len == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_code <= '0;
      dec       <= 1'b0;
      addr      <= '0;
      len       <= '0;
      working   <= 1'b0;
    end else begin
      if (load && !working) begin
        kind_code <= ld_kind;
        dec       <= ld_dec;
        addr      <= ld_addr;
        len       <= ld_len;
        working   <= 1'b1;
      end else begin
        if (svc_begin) begin
          len <= dec_len(len);
          if (tc) working <= 1'b0;
        end
        if (adv) addr <= step_addr(addr, dec, wrap16);
      end
    end
  end

  // R3: every visit takes one off the length
  p_len_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    svc_begin |=> len == L_W'($past(len) - 1'b1));

  // R6: page mode never touches the upper address bits
  p_page_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap16) |=> addr[A_W-1:PG_W] == $past(addr[A_W-1:PG_W]));

  // R1: a load aimed at an armed channel leaves its address alone
  p_load_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (load && working && !adv) |=> addr == $past(addr));

endmodule

// File: rtl/dma4_status.sv
module dma4_status #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set,
  input  logic           clr,
  output logic [NCH-1:0] stat
);

  always_ff @(posedge clk) begin
    if (!rst_n)   stat <= '0;
    else if (clr) stat <= set;
    else          stat <= stat | set;
  end

  // R9: without a clear no bit is ever lost
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stat & $past(stat)) == $past(stat)));

endmodule

// File: rtl/dma4_seqr.sv
module dma4_seqr
  import dma4_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int D_W   = 8,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [NCH-1:0]   working,
  input  xfer_kind_e       kind,
  input  logic [NCH-1:0]   dev_in_valid,
  input  logic [NCH-1:0]   dev_out_ready,
  input  logic [D_W-1:0]   mem_rdata,
  output logic [IDX_W-1:0] idx,
  output logic [NCH-1:0]   svc_begin,
  output logic [NCH-1:0]   adv_v,
  output logic             mem_re,
  output logic             mem_we,
  output logic [NCH-1:0]   dev_in_ready,
  output logic [NCH-1:0]   dev_out_valid,
  output logic [D_W-1:0]   hold,
  output logic             busy
);

  seq_state_e       state, state_n;
  logic [IDX_W-1:0] idx_n;
  logic [NCH-1:0]   sel;
  logic             in_done, out_done, adv, last;

  assign sel           = NCH'(1) << idx;
  assign last          = (idx == IDX_W'(NCH - 1));
  assign in_done       = (state == S_DIN)  && dev_in_valid[idx];
  assign out_done      = (state == S_DOUT) && dev_out_ready[idx];
  assign adv           = in_done || out_done;
  assign adv_v         = adv ? sel : '0;
  assign svc_begin     = ((state == S_SCAN) && working[idx]) ? sel : '0;
  assign dev_in_ready  = (state == S_DIN)  ? sel : '0;
  assign dev_out_valid = (state == S_DOUT) ? sel : '0;
  assign mem_we        = in_done && (kind == XK_DEV2MEM);
  assign mem_re        = (state == S_MRD);
  assign busy          = (state != S_IDLE);

  always_comb begin
    state_n = state;
    idx_n   = idx;
    case (state)
      S_IDLE: if (step) begin
        state_n = S_SCAN;
        idx_n   = '0;
      end
      S_SCAN: begin
        if (working[idx]) begin
          state_n = (kind == XK_MEM2DEV) ? S_MRD : S_DIN;
        end else if (last) begin
          state_n = S_IDLE;
        end else begin
          idx_n = idx + IDX_W'(1);
        end
      end
      S_MRD:  state_n = S_MCAP;
      S_MCAP: state_n = S_DOUT;
      S_DIN, S_DOUT: if (adv) begin
        if (last) state_n = S_IDLE;
        else begin
          state_n = S_SCAN;
          idx_n   = idx + IDX_W'(1);
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      idx   <= '0;
      hold  <= '0;
    end else begin
      state <= state_n;
      idx   <= idx_n;
      if (state == S_MCAP) hold <= mem_rdata;
    end
  end

  // R8: at most one device-input request at a time
  p_ready_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_in_ready));

  // R11: a pass that has ended only restarts through a new step
  p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !step) |=> !busy);

endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int A_W  = 24,
  parameter int L_W  = 16,
  parameter int D_W  = 8,
  parameter int PG_W = 16,
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_ch,
  input  logic [1:0]       cfg_kind,
  input  logic             cfg_dec,
  input  logic [A_W-1:0]   cfg_addr,
  input  logic [L_W-1:0]   cfg_len,
  input  logic             addr_wrap16,
  input  logic             step,
  output logic             busy,
  output logic [NCH-1:0]   working,
  output logic [NCH-1:0]   status,
  input  logic             status_clr,
  output logic [NCH-1:0]   eot,
  output logic [A_W-1:0]   mem_addr,
  output logic             mem_re,
  output logic             mem_we,
  output logic [D_W-1:0]   mem_wdata,
  input  logic [D_W-1:0]   mem_rdata,
  input  logic [NCH-1:0]   dev_in_valid,
  output logic [NCH-1:0]   dev_in_ready,
  input  logic [NCH*D_W-1:0] dev_in_data,
  output logic [NCH-1:0]   dev_out_valid,
  input  logic [NCH-1:0]   dev_out_ready,
  output logic [D_W-1:0]   dev_out_data
);

  logic [1:0]       kind_a [NCH];
  logic             dec_a  [NCH];
  logic [A_W-1:0]   addr_a [NCH];
  logic [L_W-1:0]   len_a  [NCH];
  logic [NCH-1:0]   svc_begin, adv_v, tc_v, load_v;
  logic [IDX_W-1:0] idx;
  xfer_kind_e       cur_kind;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign load_v[i] = cfg_we && (cfg_ch == IDX_W'(i));

    dma4_chan #(.A_W(A_W), .L_W(L_W), .PG_W(PG_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_v[i]),
      .ld_kind   (cfg_kind),
      .ld_dec    (cfg_dec),
      .ld_addr   (cfg_addr),
      .ld_len    (cfg_len),
      .svc_begin (svc_begin[i]),
      .adv       (adv_v[i]),
      .wrap16    (addr_wrap16),
      .kind_code (kind_a[i]),
      .dec       (dec_a[i]),
      .addr      (addr_a[i]),
      .len       (len_a[i]),
      .working   (working[i]),
      .tc        (tc_v[i])
    );

    // R3: terminal visit disarms the channel and flags it
    p_eot_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eot[i] |=> (!working[i] && status[i]));
  end

  assign cur_kind  = kind_of(kind_a[idx]);
  assign mem_addr  = addr_a[idx];
  assign mem_wdata = dev_in_data[int'(idx)*D_W +: D_W];
  assign eot       = tc_v;

  dma4_seqr #(.NCH(NCH), .D_W(D_W), .IDX_W(IDX_W)) u_seqr (
    .clk           (clk),
    .rst_n         (rst_n),
    .step          (step),
    .working       (working),
    .kind          (cur_kind),
    .dev_in_valid  (dev_in_valid),
    .dev_out_ready (dev_out_ready),
    .mem_rdata     (mem_rdata),
    .idx           (idx),
    .svc_begin     (svc_begin),
    .adv_v         (adv_v),
    .mem_re        (mem_re),
    .mem_we        (mem_we),
    .dev_in_ready  (dev_in_ready),
    .dev_out_valid (dev_out_valid),
    .hold          (dev_out_data),
    .busy          (busy)
  );

  dma4_status #(.NCH(NCH)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (tc_v),
    .clr   (status_clr),
    .stat  (status)
  );

  // R3: one channel terminates at a time
  p_eot_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eot));

  // R4: the shared memory port never reads and writes together
  p_mem_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R8: an unanswered device request is held on the same channel
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((dev_in_ready != '0) && ((dev_in_ready & dev_in_valid) == '0))
      |=> dev_in_ready == $past(dev_in_ready));

  // R10: read data reaches the device two cycles after the read strobe
  p_rd_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |-> ##2 (dev_out_valid != '0));

endmodule

// File: tb/dma4_seq_test.sv
module dma4_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [1:0]  cfg_kind = '0;
  logic        cfg_dec = 1'b0;
  logic [23:0] cfg_addr = '0;
  logic [15:0] cfg_len = '0;
  logic        addr_wrap16 = 1'b0;
  logic        step = 1'b0;
  logic        status_clr = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [3:0]  dev_in_valid = '0;
  logic [3:0]  dev_out_ready = '0;
  logic [31:0] dev_in_data;
  logic        busy, mem_re, mem_we;
  logic [3:0]  working, status, eot, dev_in_ready, dev_out_valid;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata, dev_out_data;

  dma4_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_kind(cfg_kind), .cfg_dec(cfg_dec), .cfg_addr(cfg_addr),
    .cfg_len(cfg_len), .addr_wrap16(addr_wrap16), .step(step),
    .busy(busy), .working(working), .status(status),
    .status_clr(status_clr), .eot(eot), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_in_valid(dev_in_valid),
    .dev_in_ready(dev_in_ready), .dev_in_data(dev_in_data),
    .dev_out_valid(dev_out_valid), .dev_out_ready(dev_out_ready),
    .dev_out_data(dev_out_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { int ch; int kind; int addr; bit tc; } exp_t;
  exp_t q[$];
  int   m_len[4], m_addr[4], m_kind[4], eot_exp[4], eot_seen[4];
  bit   m_dec[4];
  logic [3:0] m_work = '0, m_stat = '0;
  bit   wrap_m = 0;
  logic [7:0] bmem [int];
  int   dcnt[4] = '{0, 0, 0, 0};
  bit   stall_en = 0, dev_hold = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [7:0] memval(input int a);
    if (bmem.exists(a)) return bmem[a];
    return 8'((a * 7) ^ 'h5A);
  endfunction

  function automatic int next_addr(input int a, input bit down, input bit pg);
    int lo;
    if (pg) begin
      lo = a % 65536;
      lo = down ? (lo + 65535) % 65536 : (lo + 1) % 65536;
      return (a - (a % 65536)) + lo;
    end
    return down ? (a + 16777215) % 16777216 : (a + 1) % 16777216;
  endfunction

  function automatic void model_step();
    for (int c = 0; c < 4; c++) begin
      if (m_work[c]) begin
        exp_t e;
        e.ch = c; e.kind = m_kind[c]; e.addr = m_addr[c]; e.tc = (m_len[c] == 0);
        if (e.tc) begin
          m_work[c] = 1'b0; m_stat[c] = 1'b1; eot_exp[c]++;
        end
        m_len[c] = (m_len[c] + 65535) % 65536;
        q.push_back(e);
        m_addr[c] = next_addr(m_addr[c], m_dec[c], wrap_m);
      end
    end
  endfunction

  // ---------------- device and memory responders ----------------
  always_comb begin
    for (int c = 0; c < 4; c++) dev_in_data[c*8 +: 8] = 8'(c * 64 + dcnt[c]);
  end

  initial begin
    forever begin
      @(posedge clk);
      if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
      if (mem_re) mem_rdata <= memval(int'(mem_addr));
      for (int c = 0; c < 4; c++)
        if (dev_in_ready[c] && dev_in_valid[c]) dcnt[c] <= dcnt[c] + 1;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dev_in_valid  <= dev_hold ? 4'h0 : (stall_en ? lfsr[3:0] : 4'hF);
      dev_out_ready <= dev_hold ? 4'h0 : (stall_en ? lfsr[7:4] : 4'hF);
    end
  end

  // ---------------- per-cycle monitor ----------------
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !finished) begin
        logic [3:0] hs_in, hs_out;
        hs_in  = dev_in_ready & dev_in_valid;
        hs_out = dev_out_valid & dev_out_ready;
        if (eot != 0) begin
          chk(q.size() > 0 && q[0].tc && eot == (4'b1 << q[0].ch),
              "R3 eot on terminal visit", eot, q.size() > 0 ? (1 << q[0].ch) : 0);
          for (int c = 0; c < 4; c++) if (eot[c]) eot_seen[c]++;
        end
        if (mem_we && hs_in == 0) chk(0, "R8 write without handshake", mem_we, 0);
        if (mem_re) begin
          chk(q.size() > 0 && q[0].kind == 2 && int'(mem_addr) == q[0].addr,
              wrap_m ? "R6 read address" : "R5 read address", mem_addr,
              q.size() > 0 ? q[0].addr : -1);
        end
        if (hs_in != 0 || hs_out != 0) begin
          if (q.size() == 0) begin
            chk(0, "R7 or R11 unexpected transfer", hs_in | hs_out, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk((hs_in | hs_out) == (4'b1 << e.ch), "R2 channel order", hs_in | hs_out, 1 << e.ch);
            case (e.kind)
              0: chk(hs_in != 0 && !mem_we, "R4 verify has no memory access", mem_we, 0);
              1: begin
                chk(hs_in != 0 && mem_we, "R4 device to memory write", mem_we, 1);
                chk(int'(mem_addr) == e.addr, wrap_m ? "R6 write address" : "R5 write address",
                    mem_addr, e.addr);
                chk(mem_wdata == 8'(e.ch * 64 + dcnt[e.ch]), "R4 write data",
                    mem_wdata, 8'(e.ch * 64 + dcnt[e.ch]));
              end
              default: begin
                chk(hs_out != 0 && !mem_we, "R4 memory to device", hs_out, 1 << e.ch);
                chk(dev_out_data == memval(e.addr), "R10 read data to device",
                    dev_out_data, memval(e.addr));
              end
            endcase
          end
        end
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic load(input int c, input int k, input bit d, input int a, input int l);
    @(posedge clk);
    cfg_ch <= 2'(c); cfg_kind <= 2'(k); cfg_dec <= d;
    cfg_addr <= 24'(a); cfg_len <= 16'(l); cfg_we <= 1'b1;
    @(posedge clk);
    cfg_we <= 1'b0;
    if (!m_work[c]) begin
      m_kind[c] = (k >= 2) ? 2 : k; m_dec[c] = d; m_addr[c] = a; m_len[c] = l;
      m_work[c] = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic set_wrap(input bit w);
    @(posedge clk);
    addr_wrap16 <= w;
    wrap_m = w;
    @(negedge clk);
  endtask

  task automatic post_step_checks(input string tag);
    chk(q.size() == 0, "R2 every armed channel served once", q.size(), 0);
    chk(working == m_work, "R3 armed mask after step", working, m_work);
    chk(status == m_stat, "R9 sticky status after step", status, m_stat);
    for (int c = 0; c < 4; c++)
      chk(eot_seen[c] == eot_exp[c], "R3 eot count", eot_seen[c], eot_exp[c]);
    if (tag.len() == 0) chk(!busy, "R11 busy low at end", busy, 0);
  endtask

  task automatic do_step(input bit hold2);
    model_step();
    @(posedge clk);
    step <= 1'b1;
    @(posedge clk);
    if (hold2) @(posedge clk);
    step <= 1'b0;
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    post_step_checks("");
  endtask

  task automatic clear_status();
    @(posedge clk);
    status_clr <= 1'b1;
    @(posedge clk);
    status_clr <= 1'b0;
    m_stat = '0;
    @(negedge clk);
    chk(status == 4'h0, "R9 status clear", status, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (4) @(posedge clk);
    rst_n <= 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(working == 0 && status == 0, "R1 reset idle", {working, status}, 0);
    chk(!busy && !mem_we && !mem_re && eot == 0, "R1 reset outputs quiet", busy, 0);

    // R7 empty step
    do_step(0);

    // R3 terminal: length 2 gives three transfers
    load(1, 0, 0, 'h000100, 2);
    chk(working == 4'b0010, "R1 load arms channel", working, 4'b0010);
    do_step(0);
    do_step(0);
    chk(working[1], "R3 still armed before terminal", working, 4'b0010);
    do_step(0);
    chk(!working[1] && status[1], "R3 disarmed after terminal", {working, status}, 4'b0010);
    do_step(0); // R9 status stays set, R7 nothing more happens
    clear_status();

    // all channels, full addressing, R5 both directions, crossing 0x12FFFF
    set_wrap(0);
    load(0, 1, 0, 'h12FFFE, 3);
    load(1, 2, 1, 'h000002, 3);
    load(2, 0, 0, 'h000010, 1);
    load(3, 3, 1, 'h400001, 4);
    // R1 load to an armed channel is ignored
    load(0, 2, 1, 'h777777, 9);
    chk(working == 4'hF, "R1 ignored load keeps mask", working, 4'hF);
    for (int i = 0; i < 5; i++) do_step(0);
    chk(working == 4'h0, "R3 all channels finished", working, 0);
    clear_status();

    // R6 page mode, both directions across the page edge
    set_wrap(1);
    load(0, 1, 0, 'h34FFFE, 4);
    load(3, 2, 1, 'h560001, 4);
    stall_en = 1;
    for (int i = 0; i < 5; i++) do_step(0);
    stall_en = 0;

    // R8 device holds off: sequencer waits on the channel
    load(2, 0, 0, 'h000000, 0);
    dev_hold = 1;
    model_step();
    @(posedge clk); step <= 1'b1;
    @(posedge clk); step <= 1'b0;
    repeat (10) @(negedge clk);
    chk(busy, "R8 waits while device stalls", busy, 1);
    chk(q.size() == 1, "R8 no transfer during stall", q.size(), 1);
    chk(dev_in_ready == 4'b0100, "R8 ready held on channel", dev_in_ready, 4'b0100);
    dev_hold = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    post_step_checks("");

    // R11 step held high while busy starts only one pass
    set_wrap(0);
    load(1, 2, 0, 'h001000, 3);
    do_step(1);

    // mixed patterns
    for (int it = 0; it < 150; it++) begin
      set_wrap(bit'($urandom_range(0, 1)));
      for (int c = 0; c < 4; c++) begin
        if (!m_work[c] && $urandom_range(0, 2) == 0) begin
          int a;
          a = int'($urandom_range(0, 255)) * 65536;
          a += ($urandom_range(0, 1) == 1) ? 65533 + int'($urandom_range(0, 2))
                                           : int'($urandom_range(0, 2));
          load(c, int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), a,
               int'($urandom_range(0, 5)));
        end
      end
      stall_en = (it % 2) == 1;
      do_step(it % 11 == 0);
      if (it % 7 == 0) clear_status();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule